// File: doc/BRIEF.md
# SMI Command and Feature Negotiation

This block sits beside a power-management register space. It decodes writes to a power-management control port and runs a one-time handshake in which firmware agrees with the host on a set of SMI features. The host's supported features are a fixed 64-bit parameter. Software writes a 64-bit requested mask and then writes the features-ok register to ask for that set. If the request is a subset of the host set, it is latched as the negotiated mask and features-ok reads 1. After that point the negotiated mask cannot change until reset.

A byte written to the control port has one of three effects. It may be one of the two ACPI mode commands, which produce a one-cycle pulse on the matching mode output. Otherwise it raises a one-cycle SMI, but only while the APMC enable bit of the SMI enable register is set. The SMI goes to every CPU when the broadcast feature has been negotiated, and otherwise only to the CPU that made the write. A lock bit in the power-management control word makes itself and the global SMI enable bit read-only.

Top module: `smi_neg_top`

## Requirements
- R1: While reset is asserted (rstN low), and after it is released, the requested mask, negotiated mask, features-ok, SMI enable register and power-management control word all read zero, and no pulse output is high.
- R2: A write with wrSel=0 loads wrData into the requested mask. The new value is visible on reqMask in the cycle after the write.
- R3: A write with wrSel=1, made while features-ok is 0 and the requested mask holds no bit outside HOST_FEATURES, copies the requested mask to negMask and sets featOk in the cycle after the write.
- R4: A write with wrSel=1 while the requested mask holds any bit outside HOST_FEATURES leaves featOk at 0 and leaves negMask unchanged.
- R5: Once featOk is 1, further wrSel=1 writes have no effect. negMask holds its value even when the requested mask is rewritten.
- R6: A wrSel=2 write with wrData[7:0]=0xF0 pulses acpiOnPulse, and one with 0xF1 pulses acpiOffPulse. Neither of these writes raises any SMI.
- R7: A wrSel=2 write of any other byte raises an SMI only when bit 5 (APMC enable) of the SMI enable register is 1. The SMI enable register is written with wrSel=3 from wrData[31:0].
- R8: When negMask bit 0 (broadcast) is 1, an SMI sets every bit of smiPulse. When that bit is 0, an SMI sets only bit wrCpu of smiPulse.
- R9: The power-management control word is written with wrSel=4 from wrData[15:0]. Once its bit 4 (lock) is 1, bit 4 of that word and bit 0 of the SMI enable register ignore writes. All other bits stay writable.
- R10: acpiOnPulse, acpiOffPulse and smiPulse are high only in the cycle that directly follows the command write that caused them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrSel | input | 3 | Target: 0 request mask, 1 features-ok, 2 command port, 3 SMI enable, 4 PM control |
| wrData | input | FEAT_W (64) | Write data |
| wrCpu | input | CPU_W (2) | Index of the CPU that makes the write |
| acpiOnPulse | output | 1 | ACPI-enable command pulse |
| acpiOffPulse | output | 1 | ACPI-disable command pulse |
| smiPulse | output | NCPU (4) | Per-CPU SMI pulse |
| featOk | output | 1 | Negotiation complete |
| reqMask | output | FEAT_W (64) | Requested feature mask |
| negMask | output | FEAT_W (64) | Negotiated feature mask |
| smiEnReg | output | SMIEN_W (32) | SMI enable register |
| pmConReg | output | PMCON_W (16) | Power-management control word |

## Verification
The bench first negotiates with a request that has a bit outside the host set. A design that latched anyway would show featOk high or a nonzero negMask. It then negotiates with a valid set and tries to renegotiate. A design without the one-time lock would let negMask follow the new request. It issues SMIs before and after broadcast is negotiated, which catches a design that always broadcasts or drops the requester index. It also sends the two ACPI codes with APMC enabled, where a design that also raised an SMI would be caught. After the lock bit is set, it writes both frozen bits, so a lock that is not sticky, or that freezes the wrong bits, shows up on the register outputs.

// File: rtl/smi_neg_pkg.sv
package smi_neg_pkg;

  typedef enum logic [2:0] {
    SEL_REQ   = 3'd0,
    SEL_OK    = 3'd1,
    SEL_CMD   = 3'd2,
    SEL_SMIEN = 3'd3,
    SEL_PMCON = 3'd4
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ldReq;
    logic tryNeg;
    logic ldSmiEn;
    logic ldPmCon;
  } dpStrobe_t;

  localparam logic [7:0] CMD_ACPI_ON  = 8'hF0;
  localparam logic [7:0] CMD_ACPI_OFF = 8'hF1;
  localparam int BCAST_BIT   = 0;
  localparam int APMC_EN_BIT = 5;
  localparam int GBL_SMI_BIT = 0;
  localparam int LOCK_BIT    = 4;

endpackage

// File: rtl/smi_neg_ctrl.sv
module smi_neg_ctrl
  import smi_neg_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int CPU_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrSel,
  input  logic [7:0]       cmdByte,
  input  logic [CPU_W-1:0] wrCpu,
  input  logic             apmcEn,
  input  logic             bcastOk,
  output dpStrobe_t        strb,
  output logic             acpiOnPulse,
  output logic             acpiOffPulse,
  output logic [NCPU-1:0]  smiPulse
);

  logic            isCmd;
  logic            isAcpiOn;
  logic            isAcpiOff;
  logic            smiFire;
  logic [NCPU-1:0] reqOneHot;
  logic [NCPU-1:0] smiTarget;

  always_comb begin
    strb.ldReq   = wrEn && (wrSel == SEL_REQ);
    strb.tryNeg  = wrEn && (wrSel == SEL_OK);
    strb.ldSmiEn = wrEn && (wrSel == SEL_SMIEN);
    strb.ldPmCon = wrEn && (wrSel == SEL_PMCON);
  end

  assign isCmd     = wrEn && (wrSel == SEL_CMD);
  assign isAcpiOn  = isCmd && (cmdByte == CMD_ACPI_ON);
  assign isAcpiOff = isCmd && (cmdByte == CMD_ACPI_OFF);
  assign smiFire   = isCmd && !isAcpiOn && !isAcpiOff && apmcEn;

  always_comb begin
    for (int i = 0; i < NCPU; i++) begin
      reqOneHot[i] = (wrCpu == CPU_W'(i));
    end
  end

  assign smiTarget = bcastOk ? {NCPU{1'b1}} : reqOneHot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acpiOnPulse  <= 1'b0;
      acpiOffPulse <= 1'b0;
      smiPulse     <= '0;
    end else begin
      acpiOnPulse  <= isAcpiOn;
      acpiOffPulse <= isAcpiOff;
      smiPulse     <= smiFire ? smiTarget : '0;
    end
  end

  // R6: mode commands never come with an SMI
  a_r6_acpi_no_smi: assert property (@(posedge clk) disable iff (!rstN)
    (acpiOnPulse || acpiOffPulse) |-> (smiPulse == '0));

  a_r6_one_mode: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({acpiOnPulse, acpiOffPulse}));

  // R7: an SMI requires APMC enable at the time of the write
  a_r7_smi_needs_apmc: assert property (@(posedge clk) disable iff (!rstN)
    (smiPulse != '0) |-> $past(apmcEn));

  // R8: target selection
  a_r8_single_target: assert property (@(posedge clk) disable iff (!rstN)
    ((smiPulse != '0) && !$past(bcastOk)) |-> ($countones(smiPulse) == 1));

  a_r8_bcast_all: assert property (@(posedge clk) disable iff (!rstN)
    ((smiPulse != '0) && $past(bcastOk)) |-> (&smiPulse));

  // R10: a pulse only follows a command write
  a_r10_pulse_from_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (acpiOnPulse || acpiOffPulse || (smiPulse != '0)) |-> $past(isCmd));

endmodule

// File: rtl/smi_neg_datapath.sv
module smi_neg_datapath
  import smi_neg_pkg::*;
#(
  parameter int             FEAT_W        = 64,
  parameter int             SMIEN_W       = 32,
  parameter int             PMCON_W       = 16,
  parameter logic [FEAT_W-1:0] HOST_FEATURES = 64'hB
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strb,
  input  logic [FEAT_W-1:0]  wrData,
  output logic [FEAT_W-1:0]  reqMask,
  output logic [FEAT_W-1:0]  negMask,
  output logic               featOk,
  output logic [SMIEN_W-1:0] smiEn,
  output logic [PMCON_W-1:0] pmCon
);

  localparam logic [SMIEN_W-1:0] SMIEN_FRZ = SMIEN_W'(1) << GBL_SMI_BIT;
  localparam logic [PMCON_W-1:0] PMCON_FRZ = PMCON_W'(1) << LOCK_BIT;

  logic               reqValid;
  logic               locked;
  logic [SMIEN_W-1:0] smiEnFrz;
  logic [PMCON_W-1:0] pmConFrz;

  assign reqValid = ((reqMask & ~HOST_FEATURES) == '0);
  assign locked   = pmCon[LOCK_BIT];
  assign smiEnFrz = locked ? SMIEN_FRZ : '0;
  assign pmConFrz = locked ? PMCON_FRZ : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqMask <= '0;
      negMask <= '0;
      featOk  <= 1'b0;
      smiEn   <= '0;
      pmCon   <= '0;
    end else begin
      if (strb.ldReq) begin
        reqMask <= wrData;
      end
      if (strb.tryNeg && !featOk && reqValid) begin
        negMask <= reqMask;
        featOk  <= 1'b1;
      end
      if (strb.ldSmiEn) begin
        smiEn <= (wrData[SMIEN_W-1:0] & ~smiEnFrz) | (smiEn & smiEnFrz);
      end
      if (strb.ldPmCon) begin
        pmCon <= (wrData[PMCON_W-1:0] & ~pmConFrz) | (pmCon & pmConFrz);
      end
    end
  end

  // R3: valid request is latched
  a_r3_latch_subset: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tryNeg && !featOk && reqValid) |=> (featOk && (negMask == $past(reqMask))));

  // R4: invalid request is refused
  a_r4_reject: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tryNeg && !featOk && !reqValid) |=> (!featOk && $stable(negMask)));

  // R5: once done, stays done
  a_r5_once_only: assert property (@(posedge clk) disable iff (!rstN)
    featOk |=> (featOk && $stable(negMask)));

  // R9: lock is sticky and guards the global enable
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> (pmCon[LOCK_BIT] && (smiEn[GBL_SMI_BIT] == $past(smiEn[GBL_SMI_BIT]))));

  // R1: negotiated state only ever comes with features-ok
  a_r1_neg_needs_ok: assert property (@(posedge clk) disable iff (!rstN)
    !featOk |-> (negMask == '0));

endmodule

// File: rtl/smi_neg_top.sv
module smi_neg_top
  import smi_neg_pkg::*;
#(
  parameter int                NCPU          = 4,
  parameter int                FEAT_W        = 64,
  parameter int                SMIEN_W       = 32,
  parameter int                PMCON_W       = 16,
  parameter logic [FEAT_W-1:0] HOST_FEATURES = 64'hB,
  localparam int               CPU_W         = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [2:0]         wrSel,
  input  logic [FEAT_W-1:0]  wrData,
  input  logic [CPU_W-1:0]   wrCpu,
  output logic               acpiOnPulse,
  output logic               acpiOffPulse,
  output logic [NCPU-1:0]    smiPulse,
  output logic               featOk,
  output logic [FEAT_W-1:0]  reqMask,
  output logic [FEAT_W-1:0]  negMask,
  output logic [SMIEN_W-1:0] smiEnReg,
  output logic [PMCON_W-1:0] pmConReg
);

  dpStrobe_t strb;

  smi_neg_ctrl #(
    .NCPU (NCPU),
    .CPU_W(CPU_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrSel       (wrSel),
    .cmdByte     (wrData[7:0]),
    .wrCpu       (wrCpu),
    .apmcEn      (smiEnReg[APMC_EN_BIT]),
    .bcastOk     (negMask[BCAST_BIT]),
    .strb        (strb),
    .acpiOnPulse (acpiOnPulse),
    .acpiOffPulse(acpiOffPulse),
    .smiPulse    (smiPulse)
  );

  smi_neg_datapath #(
    .FEAT_W       (FEAT_W),
    .SMIEN_W      (SMIEN_W),
    .PMCON_W      (PMCON_W),
    .HOST_FEATURES(HOST_FEATURES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .reqMask(reqMask),
    .negMask(negMask),
    .featOk (featOk),
    .smiEn  (smiEnReg),
    .pmCon  (pmConReg)
  );

endmodule

// File: tb/test_smi_neg_top.sv
`timescale 1ns/1ps
module test_smi_neg_top;

  localparam logic [63:0] HOST = 64'hB;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = '0;
  logic [63:0] wrData = '0;
  logic [1:0]  wrCpu = '0;
  logic        acpiOnPulse, acpiOffPulse, featOk;
  logic [3:0]  smiPulse;
  logic [63:0] reqMask, negMask;
  logic [31:0] smiEnReg;
  logic [15:0] pmConReg;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // model state
  logic [63:0] mReq, mNeg;
  logic        mOk;
  logic [31:0] mSmiEn;
  logic [15:0] mPmCon;

  always #4 clk = ~clk;

  smi_neg_top i_smi_neg_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .wrCpu(wrCpu), .acpiOnPulse(acpiOnPulse), .acpiOffPulse(acpiOffPulse),
    .smiPulse(smiPulse), .featOk(featOk), .reqMask(reqMask), .negMask(negMask),
    .smiEnReg(smiEnReg), .pmConReg(pmConReg)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] smiExpect(input logic [2:0] sel, input logic [7:0] b,
                                           input logic [1:0] cpu, input logic [31:0] en,
                                           input logic [63:0] neg);
    if (sel != 3'd2 || b == 8'hF0 || b == 8'hF1 || !en[5]) return 4'h0;
    return neg[0] ? 4'hF : (4'b0001 << cpu);
  endfunction

  task automatic checkAll(input string tag);
    chk({tag, " reqMask"}, reqMask, mReq);
    chk({tag, " negMask"}, negMask, mNeg);
    chk({tag, " featOk"}, {63'd0, featOk}, {63'd0, mOk});
    chk({tag, " smiEnReg"}, {32'd0, smiEnReg}, {32'd0, mSmiEn});
    chk({tag, " pmConReg"}, {48'd0, pmConReg}, {48'd0, mPmCon});
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    wrEn = 1'b0;
    mReq = '0; mNeg = '0; mOk = 1'b0; mSmiEn = '0; mPmCon = '0;
    repeat (2) @(negedge clk);
    checkAll("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after reset");
    chk("R1 pulses", {58'd0, acpiOnPulse, acpiOffPulse, smiPulse}, 64'd0);
  endtask

  task automatic doWrite(input logic [2:0] sel, input logic [63:0] d, input logic [1:0] cpu,
                         input string tag);
    logic eOn, eOff;
    logic [3:0] eSmi;
    logic [31:0] frzS;
    logic [15:0] frzP;
    @(negedge clk);
    chk("R10 idle pulses", {58'd0, acpiOnPulse, acpiOffPulse, smiPulse}, 64'd0);
    eOn  = (sel == 3'd2) && (d[7:0] == 8'hF0);
    eOff = (sel == 3'd2) && (d[7:0] == 8'hF1);
    eSmi = smiExpect(sel, d[7:0], cpu, mSmiEn, mNeg);
    frzS = mPmCon[4] ? 32'h1 : 32'h0;
    frzP = mPmCon[4] ? 16'h10 : 16'h0;
    case (sel)
      3'd0: mReq = d;
      3'd1: if (!mOk && ((mReq & ~HOST) == 64'd0)) begin mNeg = mReq; mOk = 1'b1; end
      3'd3: mSmiEn = (d[31:0] & ~frzS) | (mSmiEn & frzS);
      3'd4: mPmCon = (d[15:0] & ~frzP) | (mPmCon & frzP);
      default: ;
    endcase
    wrEn = 1'b1; wrSel = sel; wrData = d; wrCpu = cpu;
    @(negedge clk);
    wrEn = 1'b0;
    checkAll(tag);
    chk({tag, " acpiOn"}, {63'd0, acpiOnPulse}, {63'd0, eOn});
    chk({tag, " acpiOff"}, {63'd0, acpiOffPulse}, {63'd0, eOff});
    chk({tag, " smiPulse"}, {60'd0, smiPulse}, {60'd0, eSmi});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [2:0] s;
    logic [63:0] d;
    void'($urandom(32'd20240611));
    doReset();
    doWrite(3'd0, 64'h2, 2'd0, "R2 request load");
    doWrite(3'd2, 64'h42, 2'd1, "R7 no apmc no smi");
    doWrite(3'd3, 64'h20, 2'd0, "R7 apmc enable");
    doWrite(3'd2, 64'h42, 2'd2, "R8 single cpu smi");
    doWrite(3'd2, 64'hF0, 2'd3, "R6 acpi on");
    doWrite(3'd2, 64'hF1, 2'd3, "R6 acpi off");
    doWrite(3'd0, 64'h4, 2'd0, "R2 invalid request");
    doWrite(3'd1, 64'h0, 2'd0, "R4 reject invalid");
    doWrite(3'd0, 64'h3, 2'd0, "R2 valid request");
    doWrite(3'd1, 64'h0, 2'd0, "R3 latch subset");
    doWrite(3'd2, 64'h55, 2'd1, "R8 broadcast smi");
    doWrite(3'd2, 64'hF0, 2'd1, "R6 acpi on with broadcast");
    doWrite(3'd0, 64'h8, 2'd0, "R5 rewrite request");
    doWrite(3'd1, 64'h0, 2'd0, "R5 second negotiation ignored");
    doWrite(3'd4, 64'h10, 2'd0, "R9 set lock");
    doWrite(3'd3, 64'h21, 2'd0, "R9 global bit frozen");
    doWrite(3'd4, 64'h3, 2'd0, "R9 lock sticky others writable");
    doReset();
    doWrite(3'd4, 64'h0, 2'd0, "R1 lock gone after reset");
    doWrite(3'd3, 64'h1, 2'd0, "R9 global bit writable unlocked");
    for (int i = 0; i < 400; i++) begin
      s = 3'($urandom_range(0, 4));
      d = {$urandom, $urandom};
      if (s == 3'd0 && $urandom_range(0, 2) != 0) d = d & HOST;
      if (s == 3'd2) begin
        case ($urandom_range(0, 3))
          0: d[7:0] = 8'hF0;
          1: d[7:0] = 8'hF1;
          default: ;
        endcase
      end
      if (s == 3'd3 && $urandom_range(0, 1) == 0) d[5] = 1'b1;
      if (s == 3'd4 && $urandom_range(0, 3) != 0) d[4] = 1'b0;
      doWrite(s, d, 2'($urandom_range(0, 3)), "R8 random mix");
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule